// File: doc/BRIEF.md
# Configurable Sum-of-Products Plane with Uneven OR Fan-In

This block is the logic core of a small programmable array device. Twenty logical inputs are each offered to the array in true and inverted form, giving forty columns. Ninety product terms each AND together whichever literals their stored links leave connected. Eight of those terms drive per-output enables. Two drive a global set term and a global clear term. The remaining eighty are ORed into eight sum outputs. The split is deliberately uneven: four outputs collect twelve terms each and the other four collect eight.

The link memory is written one row (one product term) at a time. A row is streamed serially into a staging register. A load strobe then copies the staged row into the term named on a row-select input. Every output is combinational from the live inputs and the stored links, so the array can feed registers, enables or pins outside this block without adding latency. Reset restores every link to its unprogrammed state, and in that state every term evaluates to 0.

Top module: `andor_array`

## Requirements
- R1: While reset is high and on the cycle after it, every link reads intact (1), so `sum_out`, `oe_out`, `preset_out` and `reset_out` are all 0 for any `in_vec`.
- R2: Row bit 2i is the true-literal link and bit 2i+1 is the inverted-literal link of input i, where 1 means intact. Pair value 01 contributes `in_vec[i]`, value 10 contributes `~in_vec[i]`, and value 00 removes input i from the term.
- R3: If any pair in a row is 11 (both links intact), that term is 0 whatever the other pairs and inputs are.
- R4: A row of all zeros (every input removed) evaluates to 1.
- R5: Rows 0..7 drive `oe_out[0..7]` directly, row 88 drives `preset_out`, and row 89 drives `reset_out`.
- R6: Rows 8..87 are handed out to outputs 0..7 in ascending order as contiguous groups. An output whose bit in `WIDE_MASK` is set gets 12 rows and any other output gets 8 (the default gives 12 to outputs 2..5). `sum_out[o]` is the OR of its group.
- R7: Each cycle with `cfg_shift` high shifts `cfg_sdi` into the staging row, so the first of forty bits shifted ends in column 39. A cycle with `cfg_load` high copies the staged row into row `cfg_row`.
- R8: A load with `cfg_row` of 90 or more changes no stored row.
- R9: A load changes only the addressed row, and outputs follow `in_vec` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset; returns every link to intact |
| cfg_shift | input | 1 | Shift `cfg_sdi` into the staging row |
| cfg_sdi | input | 1 | Serial link data |
| cfg_load | input | 1 | Copy the staging row into row `cfg_row` |
| cfg_row | input | 7 | Product-term row to write |
| in_vec | input | 20 | Logical array inputs |
| sum_out | output | 8 | OR of each output's product-term group |
| oe_out | output | 8 | Per-output enable terms |
| preset_out | output | 1 | Global set term |
| reset_out | output | 1 | Global clear term |

## Verification
The embedded checks assume `cfg_shift` and `cfg_load` are never high in the same cycle. They also assume the row-select value is stable while `cfg_load` is high. The stimulus meets both conditions by driving the configuration pins only on falling clock edges, and it issues a load only after a full forty-bit shift has finished. The combinational checks inside each product term assume `in_vec` settles between evaluations. The bench changes the inputs only while no configuration traffic is in flight and samples one time unit later.

// File: rtl/aoa_pkg.sv
package aoa_pkg;

    localparam int unsigned AOA_INPUTS  = 20;
    localparam int unsigned AOA_OUTPUTS = 8;
    localparam int unsigned AOA_WIDE    = 12;
    localparam int unsigned AOA_NARROW  = 8;

    // {inverted link, true link}; 1 = link intact
    typedef enum logic [1:0] {
        PAIR_OPEN  = 2'b00,
        PAIR_TRUE  = 2'b01,
        PAIR_INV   = 2'b10,
        PAIR_BLOCK = 2'b11
    } pair_mode_e;

    function automatic pair_mode_e decode_pair(input logic [1:0] links);
        pair_mode_e m;
        case (links)
            2'b00:   m = PAIR_OPEN;
            2'b01:   m = PAIR_TRUE;
            2'b10:   m = PAIR_INV;
            default: m = PAIR_BLOCK;
        endcase
        return m;
    endfunction

    function automatic int unsigned group_width(input logic [31:0] mask,
                                                input int unsigned idx,
                                                input int unsigned wide,
                                                input int unsigned narrow);
        return mask[idx] ? wide : narrow;
    endfunction

    function automatic int unsigned group_base(input logic [31:0] mask,
                                               input int unsigned idx,
                                               input int unsigned wide,
                                               input int unsigned narrow);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < idx; k++) begin
            acc += mask[k] ? wide : narrow;
        end
        return acc;
    endfunction

endpackage

// File: rtl/aoa_link_store.sv
module aoa_link_store #(
    parameter int unsigned TERMS = 90,
    parameter int unsigned COLS  = 40,
    parameter int unsigned ROW_W = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_shift,
    input  logic                        cfg_sdi,
    input  logic                        cfg_load,
    input  logic [ROW_W-1:0]            cfg_row,
    output logic [TERMS-1:0][COLS-1:0]  links
);

    logic [COLS-1:0]             stage_q;
    logic [TERMS-1:0][COLS-1:0]  mem_q;
    logic                        row_ok;

    assign row_ok = (32'(cfg_row) < TERMS);
    assign links  = mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            mem_q   <= '1;
        end else begin
            if (cfg_shift) begin
                stage_q <= {stage_q[COLS-2:0], cfg_sdi};
            end
            if (cfg_load && row_ok) begin
                mem_q[cfg_row] <= stage_q;
            end
        end
    end

    // R1
    reset_intact_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mem_q));

    // R7
    row_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && row_ok) |=> (mem_q[$past(cfg_row)] == $past(stage_q)));

    // R8
    bad_row_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && !row_ok) |=> $stable(mem_q));

endmodule

// File: rtl/aoa_product_term.sv
module aoa_product_term
    import aoa_pkg::*;
#(
    parameter int unsigned N_IN = 20,
    localparam int unsigned COLS = 2 * N_IN
) (
    input  logic [COLS-1:0]  links,
    input  logic [N_IN-1:0]  in_vec,
    output logic             term_out
);

    logic       acc;
    logic       any_block;
    pair_mode_e mode;

    always_comb begin
        any_block = 1'b0;
        for (int i = 0; i < int'(N_IN); i++) begin
            any_block = any_block | (links[2*i] & links[2*i+1]);
        end

        acc  = 1'b1;
        mode = PAIR_OPEN;
        for (int i = 0; i < int'(N_IN); i++) begin
            mode = decode_pair(links[2*i +: 2]);
            case (mode)
                PAIR_TRUE:  acc = acc & in_vec[i];
                PAIR_INV:   acc = acc & ~in_vec[i];
                PAIR_BLOCK: acc = 1'b0;
                default:    acc = acc;
            endcase
        end
        term_out = acc;

        // R3
        if (any_block) begin
            blocked_zero_chk: assert (term_out == 1'b0);
        end
        // R4
        if (links == '0) begin
            open_row_one_chk: assert (term_out == 1'b1);
        end
    end

endmodule

// File: rtl/aoa_sum_router.sv
module aoa_sum_router
    import aoa_pkg::*;
#(
    parameter int unsigned          N_OUT  = 8,
    parameter int unsigned          WIDE   = 12,
    parameter int unsigned          NARROW = 8,
    parameter logic [N_OUT-1:0]     WIDE_MASK = 8'b0011_1100,
    parameter int unsigned          TERMS  = 90
) (
    input  logic [TERMS-1:0]  term_vec,
    output logic [N_OUT-1:0]  sum_out,
    output logic [N_OUT-1:0]  oe_out,
    output logic              preset_out,
    output logic              reset_out
);

    assign oe_out     = term_vec[N_OUT-1:0];
    assign preset_out = term_vec[TERMS-2];
    assign reset_out  = term_vec[TERMS-1];

    for (genvar g = 0; g < int'(N_OUT); g++) begin : g_grp
        localparam int unsigned LO = N_OUT +
            group_base(32'(WIDE_MASK), g, WIDE, NARROW);
        localparam int unsigned W  =
            group_width(32'(WIDE_MASK), g, WIDE, NARROW);
        assign sum_out[g] = |term_vec[LO+W-1:LO];
    end

endmodule

// File: rtl/andor_array.sv
module andor_array
    import aoa_pkg::*;
#(
    parameter int unsigned       N_IN   = AOA_INPUTS,
    parameter int unsigned       N_OUT  = AOA_OUTPUTS,
    parameter int unsigned       WIDE   = AOA_WIDE,
    parameter int unsigned       NARROW = AOA_NARROW,
    parameter logic [N_OUT-1:0]  WIDE_MASK = 8'b0011_1100,
    localparam int unsigned COLS  = 2 * N_IN,
    localparam int unsigned SUMS  = group_base(32'(WIDE_MASK), N_OUT, WIDE, NARROW),
    localparam int unsigned TERMS = N_OUT + SUMS + 2,
    localparam int unsigned ROW_W = $clog2(TERMS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_shift,
    input  logic              cfg_sdi,
    input  logic              cfg_load,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  sum_out,
    output logic [N_OUT-1:0]  oe_out,
    output logic              preset_out,
    output logic              reset_out
);

    logic [TERMS-1:0][COLS-1:0] links;
    logic [TERMS-1:0]           term_vec;

    aoa_link_store #(
        .TERMS (TERMS),
        .COLS  (COLS),
        .ROW_W (ROW_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .cfg_shift (cfg_shift),
        .cfg_sdi   (cfg_sdi),
        .cfg_load  (cfg_load),
        .cfg_row   (cfg_row),
        .links     (links)
    );

    for (genvar t = 0; t < int'(TERMS); t++) begin : g_term
        aoa_product_term #(.N_IN(N_IN)) u_pt (
            .links    (links[t]),
            .in_vec   (in_vec),
            .term_out (term_vec[t])
        );
    end

    aoa_sum_router #(
        .N_OUT     (N_OUT),
        .WIDE      (WIDE),
        .NARROW    (NARROW),
        .WIDE_MASK (WIDE_MASK),
        .TERMS     (TERMS)
    ) u_router (
        .term_vec   (term_vec),
        .sum_out    (sum_out),
        .oe_out     (oe_out),
        .preset_out (preset_out),
        .reset_out  (reset_out)
    );

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sum_out == '0 && oe_out == '0 && !preset_out && !reset_out));

endmodule

// File: tb/andor_array_bench.sv
module andor_array_bench;

    localparam int NI = 20;
    localparam int NO = 8;
    localparam int NC = 40;
    localparam int NT = 90;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_shift = 1'b0;
    logic          cfg_sdi = 1'b0;
    logic          cfg_load = 1'b0;
    logic [6:0]    cfg_row = '0;
    logic [NI-1:0] in_vec = '0;
    logic [NO-1:0] sum_out, oe_out;
    logic          preset_out, reset_out;

    logic [NC-1:0] model [NT];
    logic [31:0]   lfsr = 32'h1ACE_5EED;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 1'b0;

    always #2.5 clk = ~clk;

    andor_array u_andor_array (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
        .cfg_load(cfg_load), .cfg_row(cfg_row), .in_vec(in_vec),
        .sum_out(sum_out), .oe_out(oe_out),
        .preset_out(preset_out), .reset_out(reset_out)
    );

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    function automatic logic eval_row(input logic [NC-1:0] r, input logic [NI-1:0] x);
        logic v;
        v = 1'b1;
        for (int i = 0; i < NI; i++) begin
            if (r[2*i] && r[2*i+1]) v = 1'b0;
            else if (r[2*i] && !x[i]) v = 1'b0;
            else if (r[2*i+1] && x[i]) v = 1'b0;
        end
        return v;
    endfunction

    // packed {reset, preset, oe[7:0], sum[7:0]}
    function automatic logic [17:0] expect_out(input logic [NI-1:0] x);
        logic [17:0] e;
        int          base;
        e = '0;
        base = NO;
        for (int o = 0; o < NO; o++) begin
            int w;
            w = (o >= 2 && o <= 5) ? 12 : 8;
            for (int k = 0; k < w; k++) e[o] = e[o] | eval_row(model[base+k], x);
            base += w;
            e[8+o] = eval_row(model[o], x);
        end
        e[16] = eval_row(model[NT-2], x);
        e[17] = eval_row(model[NT-1], x);
        return e;
    endfunction

    task automatic check_now(input string req);
        logic [17:0] got, exp;
        #1;
        got = {reset_out, preset_out, oe_out, sum_out};
        exp = expect_out(in_vec);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s in=%h actual=%h expected=%h", req, in_vec, got, exp);
        end
    endtask

    // R9: inputs change with no clock edge; outputs checked one time unit later
    task automatic sweep(input string req);
        in_vec = '0;  check_now(req);
        in_vec = '1;  check_now(req);
        for (int i = 0; i < NI; i++) begin
            in_vec = NI'(1) << i; check_now(req);
        end
        for (int k = 0; k < 48; k++) begin
            step_lfsr();
            in_vec = lfsr[NI-1:0]; check_now(req);
        end
    endtask

    // R7: bit for column 39 goes first
    task automatic load_row(input int row, input logic [NC-1:0] bits);
        for (int c = NC-1; c >= 0; c--) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_sdi   = bits[c];
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_load  = 1'b1;
        cfg_row   = 7'(row);
        @(negedge clk);
        cfg_load  = 1'b0;
        if (row < NT) model[row] = bits;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int t = 0; t < NT; t++) model[t] = '1;
    endtask

    task automatic random_row(output logic [NC-1:0] r);
        for (int i = 0; i < NI; i++) begin
            step_lfsr();
            if (lfsr[4:0] == 5'd0)      r[2*i +: 2] = 2'b11;
            else if (lfsr[7:5] == 3'd1) r[2*i +: 2] = 2'b01;
            else if (lfsr[7:5] == 3'd2) r[2*i +: 2] = 2'b10;
            else                        r[2*i +: 2] = 2'b00;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] r;
        do_reset();
        // R1: unprogrammed array is silent
        sweep("R1");

        // R2 R5 R6: one literal per term, polarity and input vary with row index
        for (int t = 0; t < NT; t++) begin
            r = '0;
            r[2*(t % NI) + ((t / NI) % 2)] = 1'b1;
            load_row(t, r);
        end
        sweep("R2/R5/R6");

        // R4 R6: last row of output 3's group open -> sum_out[3] stuck at 1
        load_row(47, '0);
        sweep("R4/R6");
        // R6: first row of output 6's group (row 72) open
        load_row(72, '0);
        sweep("R6");

        // R3: enable row 3 open except pair 7 fully intact
        r = '0; r[15:14] = 2'b11;
        load_row(3, r);
        // R4: enable row 4 fully open
        load_row(4, '0);
        sweep("R3/R4");

        // R8: staged all-zero row loaded to row 100 changes nothing
        load_row(100, '0);
        sweep("R8");
        // R5: clear-term row opened
        load_row(NT-1, '0);
        sweep("R5");

        // R2 R6 R9: random configurations
        for (int round = 0; round < 2; round++) begin
            for (int t = 0; t < NT; t++) begin
                random_row(r);
                load_row(t, r);
            end
            sweep("R2/R6/R9");
        end

        // R1: reset after programming clears everything
        do_reset();
        sweep("R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule